// File: doc/BRIEF.md
# Audio Channel Interrupt Status Aggregator

This block owns the interrupt status word and the single level-sensitive interrupt line for three audio DMA channels: two playback channels (DAC1 and DAC2) and one record channel (ADC). Each channel engine pulses a completion input when it finishes a sample-count period. The block latches that completion as a pending bit, but only when the channel's interrupt enable in the serial-control register is set. It drives a summary flag and the interrupt line from the OR of the pending bits.

The serial-control register itself lives outside this block. The block sees the current register value on every cycle. On each write it also sees the strobe and the value being written. A pending bit stays set until software drops that channel's enable from 1 to 0. The status word has no write path, and it cannot be cleared by any other means. The voice-source field reads as the constant 3. The bits for the serial-port and command-block sources read as zero.

Top module: `irq_stat_agg`

## Requirements
- R1: Channel index i maps to status bit i for the completion input and the pending bit: bit 0 is ADC, bit 1 is DAC2, bit 2 is DAC1.
- R2: A completion pulse on channel i sets status bit i one cycle later only if the current serial-control value has that channel's enable set: bit 10 for ADC, bit 9 for DAC2, bit 8 for DAC1. With the enable clear, the pulse leaves the status word unchanged.
- R3: Status bit 31 is 1 exactly when any of status bits 2..0 is 1.
- R4: The interrupt output equals status bit 31 in every cycle.
- R5: A serial-control write whose new value drops a channel's enable from 1 to 0 clears that channel's pending bit one cycle later. The pending bits of the other channels are not touched.
- R6: A serial-control write that leaves an enable at 0 or at 1, or raises it from 0 to 1, does not change that channel's pending bit.
- R7: When a completion pulse and a 1-to-0 enable drop hit the same channel in the same cycle, the pending bit ends up clear.
- R8: Status bits 6..5 always read 3. Every bit other than 31, 6..5 and 2..0 always reads 0.
- R9: During and after reset, before any event, the status word is 0x00000060 and the interrupt output is low.
- R10: A pending bit stays set through idle cycles and through further completion pulses until its enable is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| done_evt | input | 3 | Completion pulse per channel, bit i = channel i |
| sc_cur | input | 32 | Current serial-control register value |
| sc_wr | input | 1 | Serial-control write strobe |
| sc_wdata | input | 32 | Serial-control value being written |
| stat_word | output | 32 | Status word |
| irq | output | 1 | Level interrupt line |

## Verification
Pending bits are registered. A completion or an enable drop presented before a clock edge shows up in the status word and on the interrupt line right after that edge. The summary bit and the interrupt line are combinational from the pending bits, so they change in that same cycle. The driver sets the inputs at the falling edge and queues the expected word for the next rising edge. The monitor compares the word shortly after that rising edge, so each comparison covers exactly one edge of latency.

// File: rtl/irq_stat_pkg.sv
package irq_stat_pkg;
  localparam int NUM_CH   = 3;
  localparam int WORD_W   = 32;
  localparam int ENA_BASE = 8;
  localparam int SUM_BIT  = 31;
  localparam int SRC_LSB  = 5;
  localparam int SRC_W    = 2;
  localparam int SRC_RST  = 3;

  // Enable bit for channel i: channel 0 (ADC) uses the highest enable bit.
  function automatic int ena_pos(input int ch);
    return ENA_BASE + (NUM_CH - 1 - ch);
  endfunction

  // Assemble the status word from the pending vector.
  function automatic logic [WORD_W-1:0] pack_status(input logic [NUM_CH-1:0] pend);
    logic [WORD_W-1:0] w;
    w = '0;
    w[NUM_CH-1:0] = pend;
    w[SRC_LSB +: SRC_W] = SRC_W'(SRC_RST);
    w[SUM_BIT] = |pend;
    return w;
  endfunction
endpackage

// File: rtl/irq_chan_pend.sv
module irq_chan_pend (
  input  logic clk,
  input  logic rst_n,
  input  logic evt,
  input  logic ena_cur,
  input  logic wr,
  input  logic ena_new,
  output logic pend,
  output logic set_hit,
  output logic drop_hit
);
  assign drop_hit = wr & ena_cur & ~ena_new;
  assign set_hit  = evt & ena_cur & ~drop_hit;

  always_ff @(posedge clk) begin
    if (!rst_n)        pend <= 1'b0;
    else if (drop_hit) pend <= 1'b0;
    else if (set_hit)  pend <= 1'b1;
  end

  // R2
  set_takes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (evt && ena_cur && !(wr && !ena_new)) |=> pend);
  // R5
  drop_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && ena_cur && !ena_new) |=> !pend);
  // R6
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!(evt && ena_cur) && !(wr && ena_cur && !ena_new)) |=> $stable(pend));
endmodule

// File: rtl/irq_stat_pack.sv
module irq_stat_pack
  import irq_stat_pkg::*;
(
  input  logic [NUM_CH-1:0] pend,
  output logic [WORD_W-1:0] stat_word,
  output logic              irq
);
  assign stat_word = pack_status(pend);
  assign irq       = |pend;
endmodule

// File: rtl/irq_stat_agg.sv
module irq_stat_agg
  import irq_stat_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] done_evt,
  input  logic [WORD_W-1:0] sc_cur,
  input  logic              sc_wr,
  input  logic [WORD_W-1:0] sc_wdata,
  output logic [WORD_W-1:0] stat_word,
  output logic              irq
);
  logic [NUM_CH-1:0] pend, set_hit, drop_hit, ena_cur, ena_new;
  logic sc_unused;

  assign sc_unused = ^{sc_cur, sc_wdata};

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    assign ena_cur[g] = sc_cur[ena_pos(g)];
    assign ena_new[g] = sc_wdata[ena_pos(g)];
    irq_chan_pend u_pend (
      .clk(clk), .rst_n(rst_n), .evt(done_evt[g]),
      .ena_cur(ena_cur[g]), .wr(sc_wr), .ena_new(ena_new[g]),
      .pend(pend[g]), .set_hit(set_hit[g]), .drop_hit(drop_hit[g])
    );
  end

  irq_stat_pack u_pack (.pend(pend), .stat_word(stat_word), .irq(irq));

  // R4
  irq_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq == stat_word[SUM_BIT]);
  // R3
  sum_or_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stat_word[SUM_BIT] == (stat_word[NUM_CH-1:0] != '0));
  // R8
  src_const_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stat_word[SRC_LSB +: SRC_W] == SRC_W'(SRC_RST));
  // R7
  drop_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (set_hit & drop_hit) == '0);
endmodule

// File: tb/test_irq_stat_agg.sv
module test_irq_stat_agg;
  logic clk = 0, rst_n = 0;
  logic [2:0] done_evt = '0;
  logic [31:0] sc_cur = '0, sc_wdata = '0;
  logic sc_wr = 0;
  logic [31:0] stat_word;
  logic irq;

  always #5 clk = ~clk;

  irq_stat_agg i_irq_stat_agg (.clk(clk), .rst_n(rst_n), .done_evt(done_evt),
    .sc_cur(sc_cur), .sc_wr(sc_wr), .sc_wdata(sc_wdata),
    .stat_word(stat_word), .irq(irq));

  typedef struct { logic [31:0] word; logic line; string tag; } exp_t;
  exp_t q[$];
  int n_run = 0, n_fail = 0;
  logic [2:0] m_pend = '0;
  logic [31:0] m_sc = '0;
  bit done = 0;

  function automatic logic [31:0] model_word(input logic [2:0] p);
    return {(p != 0), 24'd0, 2'b11, 2'b00, p};
  endfunction

  function automatic logic [2:0] ena_of(input logic [31:0] v);
    return {v[8], v[9], v[10]}; // index 2=DAC1 bit8, 1=DAC2 bit9, 0=ADC bit10
  endfunction

  task automatic check(input logic [31:0] w, input logic l,
                       input logic [31:0] ew, input logic el, input string tag);
    n_run++;
    if (w !== ew || l !== el) begin
      n_fail++;
      $display("FAIL %s: stat=%h irq=%b expected stat=%h irq=%b", tag, w, l, ew, el);
    end
  endtask

  task automatic step(input logic [2:0] evt, input logic wr,
                      input logic [31:0] wdata, input string tag);
    logic [2:0] ec, en, drop;
    exp_t it;
    @(negedge clk);
    sc_cur = m_sc; done_evt = evt; sc_wr = wr; sc_wdata = wdata;
    ec = ena_of(m_sc); en = ena_of(wdata);
    drop = wr ? (ec & ~en) : 3'b000;
    m_pend = (m_pend | (evt & ec)) & ~drop;
    if (wr) m_sc = wdata;
    it.word = model_word(m_pend); it.line = (m_pend != 0); it.tag = tag;
    q.push_back(it);
  endtask

  initial begin : monitor
    forever begin
      @(posedge clk); #2;
      if (q.size() > 0) begin
        exp_t it;
        it = q.pop_front();
        check(stat_word, irq, it.word, it.line, it.tag);
      end
    end
  end

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: stat=%h irq=%b expected completion", stat_word, irq);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #2 check(stat_word, irq, 32'h60, 1'b0, "R9 in reset");
    @(negedge clk); rst_n = 1;
    @(posedge clk); #2 check(stat_word, irq, 32'h60, 1'b0, "R9 after reset");
    step(3'b111, 0, 0, "R2 events with enables off");
    step(3'b000, 1, 32'h0000_0100, "R6 raise DAC1 enable");
    step(3'b100, 0, 0, "R1 R2 DAC1 sets bit2");
    step(3'b000, 0, 0, "R10 hold idle");
    step(3'b100, 0, 0, "R10 repeat event");
    step(3'b011, 0, 0, "R2 disabled channels ignored");
    step(3'b000, 1, 32'h0000_0700, "R6 raise all enables");
    step(3'b001, 0, 0, "R1 R3 ADC sets bit0");
    step(3'b010, 0, 0, "R1 R4 DAC2 sets bit1");
    step(3'b000, 1, 32'h0000_0700, "R6 rewrite 1 to 1");
    step(3'b000, 1, 32'h0000_0300, "R5 drop ADC only");
    step(3'b000, 1, 32'h0000_0300, "R6 rewrite 0 to 0");
    step(3'b010, 1, 32'h0000_0100, "R7 event with DAC2 drop");
    step(3'b000, 1, 32'h0000_0000, "R5 drop DAC1 irq low");
    step(3'b000, 1, 32'hFFFF_F8FF, "R8 other bits in write");
    step(3'b111, 0, 0, "R8 R3 all sources off");
    step(3'b000, 1, 32'h0000_0400, "R6 enable ADC");
    step(3'b001, 1, 32'h0000_0400, "R2 event with write keeping enable");
    step(3'b000, 0, 0, "R4 final hold");
    @(negedge clk); done_evt = 0; sc_wr = 0;
    repeat (3) @(posedge clk);
    #3;
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule